// File: doc/BRIEF.md
# Bus Trace Capture Controller

This block watches one system address bus and copies selected transactions into an on-chip trace memory. Each bus cycle presents a valid strobe, an address, a requester ID and a read/write flag. Two masked address comparators and four programmable event conditions qualify every cycle. Four sequence entries combine those events. When an entry fires it starts collection, stops collection or samples the current transaction into the trace memory.

Software configures the block through a small word-addressed register port. Through the same port it freezes, thaws or clears the buffer, re-arms collection, and reads back captured entries through an index/data register pair. In freeze-on-full mode the block locks the buffer when the last slot is written and raises a level interrupt. Software then drains the buffer, clears it and re-arms collection.

Top module: `trace_capture_ctrl`

Register addresses (cfg_addr): 0x00 control (write strobes: bit0 freeze, bit1 thaw, bit2 clear, bit3 go), 0x01 mode (bit0 freeze-on-full), 0x02 status (bits 5:0 write pointer, bit8 full, bit9 frozen, bit10 collecting, bit11 interrupt), 0x04/0x05 comparator A value/mask, 0x06/0x07 comparator B value/mask, 0x08..0x0B event conditions 0..3, 0x0C..0x0F sequence entries 0..3, 0x10 readout index, 0x11 readout data (bits 23:0 address, 27:24 requester, 28 write flag).

## Requirements
- R1: Comparator A or B hits when ((bus_addr XOR value) AND mask) is zero. Each comparator uses its own value and mask.
- R2: Event condition i is true only on a valid cycle where every enabled term holds. The terms are: requester match (bit4 enables the check against bits 3:0), comparator A hit (bit5), comparator B hit (bit6), and type (bit7 allows reads, bit8 allows writes).
- R3: A sequence entry has four slots. Slot k uses bits 3k+2 (enable) and 3k+1:3k (event index). Bit12 is Start, bit13 is Stop and bit14 is Sample. An entry fires when at least one slot is enabled and every enabled slot's event is true in that cycle. An entry with no enabled slot never fires.
- R4: A firing Start sets the collecting state, and a firing Stop clears it. When both fire in one cycle, Stop wins and collection is off afterwards.
- R5: A firing Sample writes {write flag, requester, address} at the write pointer only if collection was on before that cycle, and the pointer then advances by one. An entry that fires Stop with its sample bit set records that transaction. A Sample in the same cycle that starts collection records nothing.
- R6: In freeze-on-full mode, the write that fills the last of the 64 entries sets full and frozen and raises the interrupt. No further write lands until the buffer is cleared.
- R7: Without freeze-on-full, the write pointer wraps after 64 entries and the full flag stays set until a clear.
- R8: The interrupt is a level. It stays asserted until a thaw or a clear.
- R9: While frozen no entry is written. A freeze or clear written in the same cycle as a Sample discards that sample. A software freeze does not raise the interrupt.
- R10: A clear zeroes the pointer, full, frozen, interrupt and collecting state. Go sets collecting, and go together with clear re-arms at once.
- R11: While frozen, the data register returns the entry selected by the index register. While not frozen, it returns zero.
- R12: After reset the status, the mode and the interrupt are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus cycle present |
| bus_addr | input | ADDR_W | Bus address |
| bus_rid | input | RID_W | Requester ID |
| bus_write | input | 1 | 1 = write, 0 = read |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| irq | output | 1 | Freeze-on-full interrupt, level |

## Verification
Two pairs of functions can act in the same cycle. The first is a Start and a Stop, provoked by pointing both comparators at one address so that two entries fire on a single transaction; collection must stay off. The second is a software freeze or clear arriving together with a Sampled transaction; it is provoked by driving a control write and a matching bus cycle in the same clock, and judged by the write pointer and later readout showing that no entry landed. A behavioural model in the bench predicts status, interrupt and readout data on every clock.

// File: rtl/trc_pkg.sv
// Package: register addresses and field positions shared by the trace
// capture controller and its checker. Assumes a 5-bit word address bus.
package trc_pkg;
    localparam int REG_AW = 5;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] RA_CTRL     = 5'h00;
    localparam logic [REG_AW-1:0] RA_MODE     = 5'h01;
    localparam logic [REG_AW-1:0] RA_STATUS   = 5'h02;
    localparam logic [REG_AW-1:0] RA_AMA_VAL  = 5'h04;
    localparam logic [REG_AW-1:0] RA_AMA_MSK  = 5'h05;
    localparam logic [REG_AW-1:0] RA_AMB_VAL  = 5'h06;
    localparam logic [REG_AW-1:0] RA_AMB_MSK  = 5'h07;
    localparam logic [REG_AW-1:0] RA_EVT_BASE = 5'h08;
    localparam logic [REG_AW-1:0] RA_SEQ_BASE = 5'h0C;
    localparam logic [REG_AW-1:0] RA_RD_IDX   = 5'h10;
    localparam logic [REG_AW-1:0] RA_RD_DATA  = 5'h11;

    // control strobes
    localparam int CTL_FREEZE = 0;
    localparam int CTL_THAW   = 1;
    localparam int CTL_CLEAR  = 2;
    localparam int CTL_GO     = 3;

    // event condition fields
    localparam int EV_RID_LSB  = 0;
    localparam int EV_RID_CHK  = 4;
    localparam int EV_NEED_A   = 5;
    localparam int EV_NEED_B   = 6;
    localparam int EV_ALLOW_RD = 7;
    localparam int EV_ALLOW_WR = 8;
    localparam int EV_W        = 9;

    // sequence entry action bits
    localparam int SQ_START  = 12;
    localparam int SQ_STOP   = 13;
    localparam int SQ_SAMPLE = 14;
    localparam int SQ_W      = 15;

    // status fields
    localparam int ST_FULL    = 8;
    localparam int ST_FROZEN  = 9;
    localparam int ST_COLLECT = 10;
    localparam int ST_IRQ     = 11;

    typedef struct packed {
        logic start;
        logic stop;
        logic sample;
    } seq_act_t;
endpackage

// File: rtl/trc_addr_match.sv
// Masked address comparator. Hits when every address bit selected by the
// mask equals the programmed value. Purely combinational.
module trc_addr_match #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] cmp_val,
    input  logic [AW-1:0] cmp_mask,
    input  logic [AW-1:0] bus_addr,
    output logic          hit
);
    // compare only the masked bits
    always_comb hit = (((bus_addr ^ cmp_val) & cmp_mask) == '0);
endmodule

// File: rtl/trc_event_unit.sv
// One trace-event condition: the AND of the enabled requester, comparator
// and transaction-type terms on a valid bus cycle. Assumes RID_W <= 4.
module trc_event_unit #(
    parameter int RID_W = 4
) (
    input  logic                  bus_valid,
    input  logic [RID_W-1:0]      bus_rid,
    input  logic                  bus_write,
    input  logic [1:0]            am_hit,
    input  logic [trc_pkg::EV_W-1:0] cfg,
    output logic                  evt
);
    import trc_pkg::*;
    logic rid_ok, am_ok, type_ok;

    // evaluate each term and combine
    always_comb begin
        rid_ok  = !cfg[EV_RID_CHK] || (bus_rid == cfg[EV_RID_LSB +: RID_W]);
        am_ok   = (!cfg[EV_NEED_A] || am_hit[0]) && (!cfg[EV_NEED_B] || am_hit[1]);
        type_ok = bus_write ? cfg[EV_ALLOW_WR] : cfg[EV_ALLOW_RD];
        evt     = bus_valid && rid_ok && am_ok && type_ok;
    end
endmodule

// File: rtl/trc_seq_unit.sv
// One sequence entry's firing logic. Fires when at least one slot is
// enabled and every enabled slot's selected event is true.
module trc_seq_unit #(
    parameter int N_EVT  = 4,
    parameter int N_SLOT = 4,
    localparam int EIW    = (N_EVT > 1) ? $clog2(N_EVT) : 1,
    localparam int SLOT_W = EIW + 1
) (
    input  logic [N_EVT-1:0]         evt,
    input  logic [N_SLOT*SLOT_W-1:0] slots,
    output logic                     fire
);
    logic [N_SLOT-1:0] slot_en;
    logic [N_SLOT-1:0] slot_ok;

    for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
        logic [EIW-1:0] sel;
        // decode one slot: enable bit above the event index
        always_comb begin
            sel        = slots[k*SLOT_W +: EIW];
            slot_en[k] = slots[k*SLOT_W + EIW];
            slot_ok[k] = !slot_en[k] || evt[sel];
        end
    end

    // all enabled slots true, and at least one enabled
    always_comb fire = (|slot_en) && (&slot_ok);
endmodule

// File: rtl/trc_buffer.sv
// Trace memory with write pointer, full flag, freeze state and interrupt.
// Assumes DEPTH is a power of two. Software clear has priority over all
// other updates; a freeze or clear request discards a same-cycle write.
module trc_buffer #(
    parameter int AW    = 24,
    parameter int RID_W = 4,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH),
    localparam int EW   = AW + RID_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_req,
    input  logic          sw_freeze,
    input  logic          sw_thaw,
    input  logic          sw_clear,
    input  logic          fof_mode,
    input  logic [EW-1:0] wr_entry,
    input  logic [PW-1:0] rd_idx,
    output logic [EW-1:0] rd_entry,
    output logic [PW-1:0] wptr,
    output logic          full,
    output logic          frozen,
    output logic          irq,
    output logic          wr_fire
);
    logic [EW-1:0] mem [DEPTH];
    logic          fill_now;

    // decide whether this cycle's sample lands
    always_comb begin
        wr_fire  = sample_req && !sw_freeze && !sw_clear && !frozen && !(fof_mode && full);
        fill_now = wr_fire && (wptr == PW'(DEPTH - 1));
    end

    // write pointer and sticky full flag
    always_ff @(posedge clk) begin
        if (!rst_n || sw_clear) begin
            wptr <= '0;
            full <= 1'b0;
        end else if (wr_fire) begin
            wptr <= wptr + 1'b1;
            if (fill_now) full <= 1'b1;
        end
    end

    // freeze state: clear, then freeze sources, then thaw
    always_ff @(posedge clk) begin
        if (!rst_n || sw_clear)              frozen <= 1'b0;
        else if (sw_freeze || (fill_now && fof_mode)) frozen <= 1'b1;
        else if (sw_thaw)                    frozen <= 1'b0;
    end

    // level interrupt raised only by freeze-on-full
    always_ff @(posedge clk) begin
        if (!rst_n || sw_clear)         irq <= 1'b0;
        else if (fill_now && fof_mode)  irq <= 1'b1;
        else if (sw_thaw)               irq <= 1'b0;
    end

    // trace storage, no reset
    always_ff @(posedge clk) begin
        if (wr_fire) mem[wptr] <= wr_entry;
    end

    // readout port
    always_comb rd_entry = mem[rd_idx];
endmodule

// File: rtl/trace_capture_ctrl.sv
// Bus trace capture controller top. Holds the configuration registers,
// evaluates comparators, events and sequence entries each bus cycle, keeps
// the collecting state and drives the trace buffer. Register reads are
// combinational on cfg_addr; writes take effect at the clock edge.
module trace_capture_ctrl #(
    parameter int ADDR_W = 24,
    parameter int RID_W  = 4,
    parameter int DEPTH  = 64,
    parameter int N_EVT  = 4,
    parameter int N_SEQ  = 4,
    parameter int N_SLOT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_valid,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [RID_W-1:0]           bus_rid,
    input  logic                       bus_write,
    input  logic                       cfg_we,
    input  logic [trc_pkg::REG_AW-1:0] cfg_addr,
    input  logic [trc_pkg::REG_DW-1:0] cfg_wdata,
    output logic [trc_pkg::REG_DW-1:0] cfg_rdata,
    output logic                       irq
);
    import trc_pkg::*;

    localparam int NUM_AM = 2;
    localparam int PW     = $clog2(DEPTH);
    localparam int EW     = ADDR_W + RID_W + 1;
    localparam int EIW    = (N_EVT > 1) ? $clog2(N_EVT) : 1;
    localparam int SLOT_W = EIW + 1;

    logic [ADDR_W-1:0] am_val  [NUM_AM];
    logic [ADDR_W-1:0] am_mask [NUM_AM];
    logic [EV_W-1:0]   evt_cfg [N_EVT];
    logic [SQ_W-1:0]   seq_cfg [N_SEQ];
    logic              fof_mode;
    logic [PW-1:0]     rd_idx;
    logic              collecting;

    logic [NUM_AM-1:0] am_hit;
    logic [N_EVT-1:0]  evt;
    logic [N_SEQ-1:0]  fire;
    seq_act_t          act [N_SEQ];
    logic [N_SEQ-1:0]  start_v, stop_v, sample_v;
    logic              start_hit, stop_hit, sample_hit;
    logic              ctl_wr, sw_freeze, sw_thaw, sw_clear, sw_go;

    logic [EW-1:0]     rd_entry;
    logic [PW-1:0]     wptr;
    logic              full, frozen, wr_fire;
    logic              unused_wdata_hi;

    always_comb unused_wdata_hi = ^cfg_wdata[REG_DW-1:ADDR_W];

    // configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_AM; i++) begin
                am_val[i]  <= '0;
                am_mask[i] <= '0;
            end
            for (int i = 0; i < N_EVT; i++) evt_cfg[i] <= '0;
            for (int i = 0; i < N_SEQ; i++) seq_cfg[i] <= '0;
            fof_mode <= 1'b0;
            rd_idx   <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == RA_MODE)    fof_mode   <= cfg_wdata[0];
            if (cfg_addr == RA_RD_IDX)  rd_idx     <= cfg_wdata[PW-1:0];
            if (cfg_addr == RA_AMA_VAL) am_val[0]  <= cfg_wdata[ADDR_W-1:0];
            if (cfg_addr == RA_AMA_MSK) am_mask[0] <= cfg_wdata[ADDR_W-1:0];
            if (cfg_addr == RA_AMB_VAL) am_val[1]  <= cfg_wdata[ADDR_W-1:0];
            if (cfg_addr == RA_AMB_MSK) am_mask[1] <= cfg_wdata[ADDR_W-1:0];
            for (int i = 0; i < N_EVT; i++)
                if (cfg_addr == RA_EVT_BASE + REG_AW'(i)) evt_cfg[i] <= cfg_wdata[EV_W-1:0];
            for (int i = 0; i < N_SEQ; i++)
                if (cfg_addr == RA_SEQ_BASE + REG_AW'(i)) seq_cfg[i] <= cfg_wdata[SQ_W-1:0];
        end
    end

    // control strobes decoded from a write to the control register
    always_comb begin
        ctl_wr    = cfg_we && (cfg_addr == RA_CTRL);
        sw_freeze = ctl_wr && cfg_wdata[CTL_FREEZE];
        sw_thaw   = ctl_wr && cfg_wdata[CTL_THAW];
        sw_clear  = ctl_wr && cfg_wdata[CTL_CLEAR];
        sw_go     = ctl_wr && cfg_wdata[CTL_GO];
    end

    for (genvar a = 0; a < NUM_AM; a++) begin : g_am
        trc_addr_match #(.AW(ADDR_W)) u_match (
            .cmp_val  (am_val[a]),
            .cmp_mask (am_mask[a]),
            .bus_addr (bus_addr),
            .hit      (am_hit[a])
        );
    end

    for (genvar e = 0; e < N_EVT; e++) begin : g_evt
        trc_event_unit #(.RID_W(RID_W)) u_evt (
            .bus_valid (bus_valid),
            .bus_rid   (bus_rid),
            .bus_write (bus_write),
            .am_hit    (am_hit),
            .cfg       (evt_cfg[e]),
            .evt       (evt[e])
        );
    end

    for (genvar s = 0; s < N_SEQ; s++) begin : g_seq
        trc_seq_unit #(.N_EVT(N_EVT), .N_SLOT(N_SLOT)) u_seq (
            .evt   (evt),
            .slots (seq_cfg[s][N_SLOT*SLOT_W-1:0]),
            .fire  (fire[s])
        );
        // split the entry's action bits and gate them by its firing
        always_comb begin
            act[s].start  = seq_cfg[s][SQ_START];
            act[s].stop   = seq_cfg[s][SQ_STOP];
            act[s].sample = seq_cfg[s][SQ_SAMPLE];
            start_v[s]    = fire[s] && act[s].start;
            stop_v[s]     = fire[s] && act[s].stop;
            sample_v[s]   = fire[s] && act[s].sample;
        end
    end

    // merge actions over all entries
    always_comb begin
        start_hit  = |start_v;
        stop_hit   = |stop_v;
        sample_hit = |sample_v;
    end

    // collecting state: Stop beats Start and go; clear drops it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)                     collecting <= 1'b0;
        else if (stop_hit)              collecting <= 1'b0;
        else if (start_hit || sw_go)    collecting <= 1'b1;
        else if (sw_clear)              collecting <= 1'b0;
    end

    trc_buffer #(.AW(ADDR_W), .RID_W(RID_W), .DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_req (sample_hit && collecting),
        .sw_freeze  (sw_freeze),
        .sw_thaw    (sw_thaw),
        .sw_clear   (sw_clear),
        .fof_mode   (fof_mode),
        .wr_entry   ({bus_write, bus_rid, bus_addr}),
        .rd_idx     (rd_idx),
        .rd_entry   (rd_entry),
        .wptr       (wptr),
        .full       (full),
        .frozen     (frozen),
        .irq        (irq),
        .wr_fire    (wr_fire)
    );

    // register read mux
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            RA_MODE:    cfg_rdata[0] = fof_mode;
            RA_STATUS: begin
                cfg_rdata[PW-1:0]      = wptr;
                cfg_rdata[ST_FULL]     = full;
                cfg_rdata[ST_FROZEN]   = frozen;
                cfg_rdata[ST_COLLECT]  = collecting;
                cfg_rdata[ST_IRQ]      = irq;
            end
            RA_AMA_VAL: cfg_rdata[ADDR_W-1:0] = am_val[0];
            RA_AMA_MSK: cfg_rdata[ADDR_W-1:0] = am_mask[0];
            RA_AMB_VAL: cfg_rdata[ADDR_W-1:0] = am_val[1];
            RA_AMB_MSK: cfg_rdata[ADDR_W-1:0] = am_mask[1];
            RA_RD_IDX:  cfg_rdata[PW-1:0]     = rd_idx;
            RA_RD_DATA: if (frozen) cfg_rdata[EW-1:0] = rd_entry;
            default: begin
                for (int i = 0; i < N_EVT; i++)
                    if (cfg_addr == RA_EVT_BASE + REG_AW'(i)) cfg_rdata[EV_W-1:0] = evt_cfg[i];
                for (int i = 0; i < N_SEQ; i++)
                    if (cfg_addr == RA_SEQ_BASE + REG_AW'(i)) cfg_rdata[SQ_W-1:0] = seq_cfg[i];
            end
        endcase
    end
endmodule

// File: rtl/trc_capture_checker.sv
// Property checker for the trace capture controller, bound into the top.
// Observes collecting state, buffer state and the register port.
module trc_capture_checker #(
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       stop_hit,
    input logic                       collecting,
    input logic                       frozen,
    input logic                       full,
    input logic [PW-1:0]              wptr,
    input logic                       wr_fire,
    input logic                       fof_mode,
    input logic                       irq,
    input logic                       cfg_we,
    input logic [trc_pkg::REG_AW-1:0] cfg_addr,
    input logic [trc_pkg::REG_DW-1:0] cfg_rdata
);
    import trc_pkg::*;

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> !collecting); // R4

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> (wptr == $past(wptr) + 1'b1)); // R5

    AST_FILL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && fof_mode && wptr == PW'(DEPTH - 1)) |=> (frozen && irq && full)); // R6

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !(cfg_we && cfg_addr == RA_CTRL)) |=> full); // R7

    AST_IRQ_NEEDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> frozen); // R8

    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !cfg_we) |=> ($stable(wptr) && $stable(full))); // R9

    AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && cfg_addr == RA_RD_DATA) |-> (cfg_rdata == '0)); // R11
endmodule

bind trace_capture_ctrl trc_capture_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_hit   (stop_hit),
    .collecting (collecting),
    .frozen     (frozen),
    .full       (full),
    .wptr       (wptr),
    .wr_fire    (wr_fire),
    .fof_mode   (fof_mode),
    .irq        (irq),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_rdata  (cfg_rdata)
);

// File: tb/trace_capture_ctrl_bench.sv
// Bench: drives bus and register traffic at the falling edge, checks irq and
// the addressed register against a behavioural model every cycle.
module trace_capture_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_CTRL = 5'h00, A_MODE = 5'h01, A_STAT = 5'h02;
    localparam logic [4:0] A_AAV = 5'h04, A_AAM = 5'h05, A_ABV = 5'h06, A_ABM = 5'h07;
    localparam logic [4:0] A_EVT = 5'h08, A_SEQ = 5'h0C, A_IDX = 5'h10, A_DATA = 5'h11;

    logic        clk = 0, rst_n = 0;
    logic        bus_valid = 0, bus_write = 0, cfg_we = 0;
    logic [23:0] bus_addr = 0;
    logic [3:0]  bus_rid = 0;
    logic [4:0]  cfg_addr = A_STAT;
    logic [31:0] cfg_wdata = 0, cfg_rdata;
    logic        irq;

    int checks = 0, fails = 0;
    bit done = 0;
    string cur_req = "R12";

    // model state
    int          m_ptr = 0, m_idx = 0;
    bit          m_full = 0, m_frozen = 0, m_coll = 0, m_irq = 0, m_fof = 0;
    logic [28:0] m_mem [64];
    logic [23:0] m_av [2], m_am [2];
    logic [31:0] m_ev [4], m_sq [4];

    trace_capture_ctrl u_trace_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_rid(bus_rid), .bus_write(bus_write), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        return 32'(m_ptr) | (32'(m_full) << 8) | (32'(m_frozen) << 9)
             | (32'(m_coll) << 10) | (32'(m_irq) << 11);
    endfunction

    // advance the model by one clock with the given inputs
    task automatic model_step(input bit v, input logic [23:0] a, input logic [3:0] r,
                              input bit w, input bit we, input logic [4:0] ra,
                              input logic [31:0] wd);
        bit hit[2];
        bit ev[4];
        bit st = 0, sp = 0, sa = 0;
        bit ctl = we && ra == A_CTRL;
        bit clr = ctl && wd[2], frz = ctl && wd[0], thw = ctl && wd[1], go = ctl && wd[3];
        bit wr, fill;
        for (int j = 0; j < 2; j++) hit[j] = (((a ^ m_av[j]) & m_am[j]) == 0);
        for (int i = 0; i < 4; i++)
            ev[i] = v && (!m_ev[i][4] || r == m_ev[i][3:0]) && (!m_ev[i][5] || hit[0])
                    && (!m_ev[i][6] || hit[1]) && (w ? m_ev[i][8] : m_ev[i][7]);
        for (int s = 0; s < 4; s++) begin
            bit any = 0, ok = 1;
            for (int k = 0; k < 4; k++)
                if (m_sq[s][3*k+2]) begin
                    any = 1;
                    if (!ev[m_sq[s][3*k +: 2]]) ok = 0;
                end
            if (any && ok) begin
                st |= m_sq[s][12]; sp |= m_sq[s][13]; sa |= m_sq[s][14];
            end
        end
        wr = sa && m_coll && !clr && !frz && !m_frozen && !(m_fof && m_full);
        fill = wr && m_ptr == 63;
        if (wr) begin
            m_mem[m_ptr] = {w, r, a};
            m_ptr = (m_ptr + 1) % 64;
            if (fill) m_full = 1;
        end
        if (clr) begin m_ptr = 0; m_full = 0; m_frozen = 0; m_irq = 0; end
        else begin
            if (frz || (fill && m_fof)) m_frozen = 1; else if (thw) m_frozen = 0;
            if (fill && m_fof) m_irq = 1; else if (thw) m_irq = 0;
        end
        if (sp) m_coll = 0; else if (st || go) m_coll = 1; else if (clr) m_coll = 0;
        if (we) begin
            case (ra)
                A_MODE: m_fof = wd[0];
                A_IDX:  m_idx = int'(wd[5:0]);
                A_AAV:  m_av[0] = wd[23:0];
                A_AAM:  m_am[0] = wd[23:0];
                A_ABV:  m_av[1] = wd[23:0];
                A_ABM:  m_am[1] = wd[23:0];
                default: begin
                    if (ra >= A_EVT && ra < A_EVT + 4) m_ev[ra - A_EVT] = wd & 32'h1FF;
                    if (ra >= A_SEQ && ra < A_SEQ + 4) m_sq[ra - A_SEQ] = wd & 32'h7FFF;
                end
            endcase
        end
    endtask

    task automatic step(input bit v, input logic [23:0] a, input logic [3:0] r, input bit w,
                        input bit we, input logic [4:0] ra, input logic [31:0] wd);
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_rid = r; bus_write = w;
        cfg_we = we; cfg_addr = ra; cfg_wdata = wd;
        #1;
        check(32'(irq), 32'(m_irq), "irq");
        if (ra == A_STAT) check(cfg_rdata, m_status(), "status");
        if (ra == A_MODE) check(cfg_rdata, 32'(m_fof), "mode");
        if (ra == A_DATA) check(cfg_rdata, m_frozen ? 32'(m_mem[m_idx]) : 32'h0, "readout");
        model_step(v, a, r, w, we, ra, wd);
    endtask

    task automatic bus(input logic [23:0] a, input logic [3:0] r, input bit w);
        step(1, a, r, w, 0, A_STAT, 0);
    endtask
    task automatic wreg(input logic [4:0] ra, input logic [31:0] wd);
        step(0, 0, 0, 0, 1, ra, wd);
    endtask
    task automatic peek(input logic [4:0] ra);
        step(0, 0, 0, 0, 0, ra, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) m_mem[i] = 0;
        for (int i = 0; i < 2; i++) begin m_av[i] = 0; m_am[i] = 0; end
        for (int i = 0; i < 4; i++) begin m_ev[i] = 0; m_sq[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        cur_req = "R12";
        peek(A_STAT); peek(A_MODE); peek(A_STAT);

        cur_req = "R2";
        wreg(A_AAV, 24'h001000); wreg(A_AAM, 24'hFFFFFF);
        wreg(A_ABV, 24'h002000); wreg(A_ABM, 24'hFFFFFF);
        wreg(A_EVT + 0, 32'h191); wreg(A_EVT + 1, 32'h1B1);
        wreg(A_EVT + 2, 32'h1D1); wreg(A_EVT + 3, 32'h100);
        wreg(A_SEQ + 0, 32'h1005); wreg(A_SEQ + 1, 32'h4004);
        wreg(A_SEQ + 2, 32'h2006); wreg(A_SEQ + 3, 32'h1000);

        cur_req = "R3";   // all-ignore entry with Start must not start
        bus(24'h000123, 1, 0); bus(24'h000124, 1, 1); peek(A_STAT);

        cur_req = "R5";   // start cycle also samples but records nothing
        bus(24'h001000, 1, 0);
        bus(24'h003000, 1, 0); bus(24'h003004, 1, 1);
        cur_req = "R2";
        bus(24'h003008, 2, 0);
        step(0, 24'h00300C, 1, 0, 0, A_STAT, 0);
        cur_req = "R5";   // stop cycle recorded via sample entry
        bus(24'h002000, 1, 1);
        cur_req = "R4";
        bus(24'h003010, 1, 0); peek(A_STAT);

        cur_req = "R4";   // both comparators on one address: Start and Stop collide
        wreg(A_ABV, 24'h001000);
        bus(24'h001000, 1, 0); bus(24'h003014, 1, 0);
        wreg(A_ABV, 24'h002000);

        cur_req = "R1";   // masked comparator A
        wreg(A_AAM, 24'hFFF000);
        bus(24'h001ABC, 1, 0); bus(24'h004000, 1, 0);

        cur_req = "R5";   // separator through the Stop entry's sample bit
        wreg(A_SEQ + 1, 32'h0); wreg(A_SEQ + 2, 32'h6006);
        bus(24'h005000, 1, 0); bus(24'h002000, 1, 0);
        wreg(A_SEQ + 1, 32'h4004); wreg(A_SEQ + 2, 32'h2006);

        cur_req = "R3";   // two-slot entry: rid-1 event AND any-write event
        wreg(A_SEQ + 3, 32'h103C);
        bus(24'h006000, 1, 0); bus(24'h006002, 2, 1); bus(24'h006004, 1, 1);
        bus(24'h006008, 1, 0);

        cur_req = "R2";   // read-only type qualifier
        wreg(A_EVT + 0, 32'h091);
        bus(24'h007000, 1, 1); bus(24'h007004, 1, 0);
        wreg(A_EVT + 0, 32'h191);

        cur_req = "R9";   // software freeze in the same cycle as a sample
        step(1, 24'h007008, 1, 0, 1, A_CTRL, 32'h1);
        bus(24'h00700C, 1, 0); peek(A_STAT);

        cur_req = "R11";
        for (int i = 0; i < m_ptr; i++) begin
            wreg(A_IDX, 32'(i)); peek(A_DATA);
        end
        wreg(A_CTRL, 32'h2); wreg(A_IDX, 0); peek(A_DATA);

        cur_req = "R7";   // wrap without freeze-on-full
        wreg(A_CTRL, 32'hC);
        for (int i = 0; i < 70; i++) bus(24'h800000 + 24'(i * 4), 1, i[0]);
        peek(A_STAT);

        cur_req = "R6";
        wreg(A_MODE, 1); peek(A_MODE); wreg(A_CTRL, 32'hC);
        for (int i = 0; i < 64; i++) bus(24'h900000 + 24'(i * 4), 1, 0);
        for (int i = 0; i < 5; i++) bus(24'hA00000 + 24'(i * 4), 1, 1);
        wreg(A_IDX, 5); peek(A_DATA); wreg(A_IDX, 63); peek(A_DATA);
        cur_req = "R8";
        repeat (4) peek(A_STAT);
        wreg(A_CTRL, 32'h2); peek(A_STAT);
        cur_req = "R6";   // still full after thaw: writes stay blocked
        bus(24'hB00000, 1, 0); peek(A_STAT);

        cur_req = "R9";   // clear in the same cycle as a sample
        step(1, 24'hB00004, 1, 0, 1, A_CTRL, 32'h4);
        cur_req = "R10";
        peek(A_STAT); bus(24'hB00008, 1, 0);
        wreg(A_CTRL, 32'h8); bus(24'hB0000C, 1, 0); peek(A_STAT);

        finish_run();
    end
endmodule